// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is a memory-mapped SPI master that works through a queue of up to 16 single-byte transfers with no processor involvement once started. Software loads a transmit RAM, a per-slot command RAM and a pair of queue pointers, takes the write lock, and sets the run bit. The controller then shifts one byte per slot out on MOSI, most significant bit first. It captures the byte returned on MISO into a receive RAM and raises a completion flag when the last slot of the queue is done.

Each slot's command byte decides what happens to chip select after that byte. With the continue bit set, the next slot follows back-to-back and select stays low. With it clear, select is released for one half SCK period before the next slot. If the final slot of a queue carries the continue bit, select stays asserted after the queue ends, so a multi-queue transaction can be built. Clearing the write lock then ends it. The transmit and receive RAMs are interleaved: slot n sends from transmit word 2n and deposits into receive word 2n+1.

The register port is a plain synchronous bus with a one-cycle read latency. Word addresses: 0x00 divisor, 0x01 format, 0x02 first slot, 0x03 last slot, 0x04 control, 0x05 status, 0x06 write lock, 0x07 device select, 0x20-0x3F transmit RAM, 0x40-0x5F receive RAM, 0x60-0x6F command RAM.

Top module: `qspi_master`

## Requirements
- R1: After reset, ss_n is all ones, sck sits high (format resets to mode 3), irq is 0, status reads 0, and the divisor reads 8.
- R2: A control write with bit 6 set starts the queue only when the write lock (word 0x06 bit 0) is 1 and the block is idle. Without the lock, the write starts nothing: select stays released and sck stays idle.
- R3: The queue visits slots from the first-slot pointer to the last-slot pointer inclusive, counting upward and wrapping from 15 to 0. Slot n transmits transmit word 2n, MSB first on mosi.
- R4: The byte sampled from miso during slot n is stored in receive word 2n+1, MSB first. Each bit is sampled at the clock edge that ends the bit's first half period.
- R5: Each SCK half period lasts max(divisor,8) clock cycles, and a byte takes 16 half periods. Format bit 1 is CPOL (the idle level) and bit 0 is CPHA. sck = CPOL XOR (half-index parity XOR CPHA) while shifting.
- R6: Command byte bit 7 set keeps select asserted straight into the next slot. Bit 7 clear releases select and holds sck idle for one half period (max(divisor,8) cycles) before the next slot.
- R7: When the last slot completes, status bit 0 becomes 1 and control bit 6 reads 0. irq equals status bit 0 AND control bit 5.
- R8: If the final slot's command bit 7 is set, select stays asserted after the queue ends. It is released once the write lock is written to 0.
- R9: Writing the status word with bit 0 at 0 clears the completion flag and drops irq.
- R10: While the queue runs, bus writes have no effect; a transmit-RAM write made mid-queue reads back unchanged afterwards.
- R11: While select is asserted, ss_n equals the bitwise inverse of the device-select register's low 8 bits (reset value 0x01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| irq | output | 1 | Completion interrupt |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 8 | Active-low device selects |

## Verification
Most internal faults surface on the SPI pins within one half SCK period. A wrong divisor count, half-index or slot pointer bends the sck or mosi waveform at the very next edge. The reference model compares sck, mosi and ss_n against its own prediction on every clock, so such a fault is reported in the cycle it appears. A bad receive-side shift or slot index stays hidden until the receive RAM is read back after the queue. A lost completion or hold state shows up on irq and ss_n one cycle after the final slot.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

    parameter int DIV_W = 8;

    typedef logic [DIV_W-1:0] div_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_GAP   = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
    } spi_fmt_t;

    function automatic div_t clamp_div(input div_t d, input div_t floor_v);
        return (d < floor_v) ? floor_v : d;
    endfunction

    function automatic logic sck_level(input spi_fmt_t f, input logic odd_half);
        return f.cpol ^ (odd_half ^ f.cpha);
    endfunction

endpackage

// File: rtl/qspi_regfile.sv
module qspi_regfile
    import qspi_pkg::*;
#(
    parameter int SLOTS   = 16,
    parameter int CS_W    = 8,
    parameter int MIN_DIV = 8,
    localparam int SLOT_W    = $clog2(SLOTS),
    localparam int RAM_WORDS = 2 * SLOTS,
    localparam int RAM_W     = SLOT_W + 1,
    localparam int ADDR_W    = $clog2(3 * RAM_WORDS + SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic              done_pulse,
    output logic              start,
    output div_t              div_q,
    output spi_fmt_t          fmt_q,
    output logic [SLOT_W-1:0] first_q,
    output logic [SLOT_W-1:0] last_q,
    output logic              lock_q,
    output logic [CS_W-1:0]   csel_q,
    output logic              irq,
    input  logic [SLOT_W-1:0] ld_slot,
    output logic [7:0]        ld_byte,
    input  logic [SLOT_W-1:0] cur_slot,
    output logic              cur_cont,
    input  logic              rx_we,
    input  logic [SLOT_W-1:0] rx_slot,
    input  logic [7:0]        rx_byte
);
    localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_FMT   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] A_LOCK  = ADDR_W'(6);
    localparam logic [ADDR_W-1:0] A_CSEL  = ADDR_W'(7);
    localparam logic [ADDR_W-1:0] A_TX    = ADDR_W'(RAM_WORDS);
    localparam logic [ADDR_W-1:0] A_RX    = ADDR_W'(2 * RAM_WORDS);
    localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(3 * RAM_WORDS);
    localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(3 * RAM_WORDS + SLOTS);

    logic [7:0] tx_mem  [RAM_WORDS];
    logic [7:0] rx_mem  [RAM_WORDS];
    logic [7:0] cmd_mem [SLOTS];
    logic       int_en_q, cont_cfg_q, stat_q;

    logic wr_ok, in_tx, in_rx, in_cmd;
    assign wr_ok  = bus_we && !busy;
    assign in_tx  = (bus_addr >= A_TX)  && (bus_addr < A_RX);
    assign in_rx  = (bus_addr >= A_RX)  && (bus_addr < A_CMD);
    assign in_cmd = (bus_addr >= A_CMD) && (bus_addr < A_END);

    assign start    = wr_ok && (bus_addr == A_CTRL) && bus_wdata[6] && lock_q;
    assign ld_byte  = tx_mem[{ld_slot, 1'b0}];
    assign cur_cont = cmd_mem[cur_slot][7];
    assign irq      = stat_q && int_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q      <= div_t'(MIN_DIV);
            fmt_q      <= '{cpol: 1'b1, cpha: 1'b1};
            first_q    <= '0;
            last_q     <= '0;
            int_en_q   <= 1'b0;
            cont_cfg_q <= 1'b0;
            stat_q     <= 1'b0;
            lock_q     <= 1'b0;
            csel_q     <= CS_W'(1);
            for (int i = 0; i < RAM_WORDS; i++) begin
                tx_mem[i] <= '0;
                rx_mem[i] <= '0;
            end
            for (int i = 0; i < SLOTS; i++) cmd_mem[i] <= '0;
        end else begin
            if (done_pulse) stat_q <= 1'b1;
            if (rx_we) rx_mem[{rx_slot, 1'b1}] <= rx_byte;
            if (wr_ok) begin
                case (bus_addr)
                    A_DIV:   div_q   <= bus_wdata[DIV_W-1:0];
                    A_FMT:   fmt_q   <= '{cpol: bus_wdata[1], cpha: bus_wdata[0]};
                    A_FIRST: first_q <= bus_wdata[SLOT_W-1:0];
                    A_LAST:  last_q  <= bus_wdata[SLOT_W-1:0];
                    A_CTRL: begin
                        int_en_q   <= bus_wdata[5];
                        cont_cfg_q <= bus_wdata[7];
                    end
                    A_STAT:  if (!bus_wdata[0]) stat_q <= 1'b0;
                    A_LOCK:  lock_q  <= bus_wdata[0];
                    A_CSEL:  csel_q  <= bus_wdata[CS_W-1:0];
                    default: begin
                        if (in_tx)  tx_mem[bus_addr[RAM_W-1:0]]   <= bus_wdata[7:0];
                        if (in_cmd) cmd_mem[bus_addr[SLOT_W-1:0]] <= bus_wdata[7:0];
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            bus_rdata <= '0;
            case (bus_addr)
                A_DIV:   bus_rdata[DIV_W-1:0]  <= div_q;
                A_FMT:   bus_rdata[5:0]        <= {4'd8, fmt_q.cpol, fmt_q.cpha};
                A_FIRST: bus_rdata[SLOT_W-1:0] <= first_q;
                A_LAST:  bus_rdata[SLOT_W-1:0] <= last_q;
                A_CTRL:  bus_rdata[7:5]        <= {cont_cfg_q, busy, int_en_q};
                A_STAT:  bus_rdata[0]          <= stat_q;
                A_LOCK:  bus_rdata[0]          <= lock_q;
                A_CSEL:  bus_rdata[CS_W-1:0]   <= csel_q;
                default: begin
                    if (in_tx)  bus_rdata[7:0] <= tx_mem[bus_addr[RAM_W-1:0]];
                    if (in_rx)  bus_rdata[7:0] <= rx_mem[bus_addr[RAM_W-1:0]];
                    if (in_cmd) bus_rdata[7:0] <= cmd_mem[bus_addr[SLOT_W-1:0]];
                end
            endcase
        end
    end

    // R2
    start_runs_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R2
    nolock_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == A_CTRL) && bus_wdata[6] && !lock_q && !busy) |=> !busy);

    // R7
    done_flag_chk: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> (stat_q && !busy));

endmodule

// File: rtl/qspi_shifter.sv
module qspi_shifter
    import qspi_pkg::*;
#(
    parameter int SLOTS   = 16,
    parameter int MIN_DIV = 8,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SLOT_W-1:0] first_q,
    input  logic [SLOT_W-1:0] last_q,
    input  div_t              div_q,
    input  spi_fmt_t          fmt_q,
    input  logic              lock_q,
    output logic [SLOT_W-1:0] ld_slot,
    input  logic [7:0]        ld_byte,
    output logic [SLOT_W-1:0] cur_slot,
    input  logic              cur_cont,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              cs_on,
    output logic              busy,
    output logic              rx_we,
    output logic [7:0]        rx_byte,
    output logic              done_pulse
);
    eng_state_e        state;
    logic [SLOT_W-1:0] slot;
    logic [3:0]        half;
    div_t              cnt;
    logic [7:0]        txsh, rxsh;
    logic              hold;

    div_t eff_div;
    logic last_tick, byte_end;

    assign eff_div    = clamp_div(div_q, div_t'(MIN_DIV));
    assign last_tick  = (cnt == eff_div - 1'b1);
    assign byte_end   = (state == ENG_SHIFT) && last_tick && (half == 4'd15);
    assign rx_we      = byte_end;
    assign rx_byte    = rxsh;
    assign done_pulse = byte_end && (slot == last_q);
    assign cur_slot   = slot;
    assign ld_slot    = (state == ENG_IDLE) ? first_q : slot + 1'b1;
    assign busy       = (state != ENG_IDLE);
    assign cs_on      = (state == ENG_SHIFT) || hold;
    assign sck        = (state == ENG_SHIFT) ? sck_level(fmt_q, half[0]) : fmt_q.cpol;
    assign mosi       = (state == ENG_SHIFT) ? txsh[7] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENG_IDLE;
            slot  <= '0;
            half  <= '0;
            cnt   <= '0;
            txsh  <= '0;
            rxsh  <= '0;
            hold  <= 1'b0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (!lock_q) hold <= 1'b0;
                    if (start) begin
                        state <= ENG_SHIFT;
                        slot  <= first_q;
                        half  <= '0;
                        cnt   <= '0;
                        txsh  <= ld_byte;
                        hold  <= 1'b0;
                    end
                end
                ENG_SHIFT: begin
                    if (!last_tick) begin
                        cnt <= cnt + 1'b1;
                    end else begin
                        cnt  <= '0;
                        half <= half + 1'b1;
                        if (!half[0])            rxsh <= {rxsh[6:0], miso};
                        else if (half != 4'd15)  txsh <= {txsh[6:0], 1'b0};
                        if (half == 4'd15) begin
                            if (slot == last_q) begin
                                state <= ENG_IDLE;
                                hold  <= cur_cont;
                            end else if (cur_cont) begin
                                slot <= slot + 1'b1;
                                txsh <= ld_byte;
                            end else begin
                                state <= ENG_GAP;
                            end
                        end
                    end
                end
                ENG_GAP: begin
                    if (!last_tick) begin
                        cnt <= cnt + 1'b1;
                    end else begin
                        cnt   <= '0;
                        half  <= '0;
                        slot  <= slot + 1'b1;
                        txsh  <= ld_byte;
                        state <= ENG_SHIFT;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // R5
    div_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < eff_div));

    // R5
    sck_steady_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == ENG_SHIFT) && !last_tick) |=> $stable(sck));

    // R6
    gap_release_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_end && !cur_cont && (slot != last_q)) |=> !cs_on);

    // R8
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_end && cur_cont && (slot == last_q)) |=> cs_on);

endmodule

// File: rtl/qspi_master.sv
module qspi_master
    import qspi_pkg::*;
#(
    parameter int SLOTS   = 16,
    parameter int CS_W    = 8,
    parameter int MIN_DIV = 8,
    localparam int SLOT_W    = $clog2(SLOTS),
    localparam int RAM_WORDS = 2 * SLOTS,
    localparam int ADDR_W    = $clog2(3 * RAM_WORDS + SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [CS_W-1:0]   ss_n
);
    logic              start, busy, done_pulse, lock_q, cur_cont, rx_we, cs_on;
    div_t              div_q;
    spi_fmt_t          fmt_q;
    logic [SLOT_W-1:0] first_q, last_q, ld_slot, cur_slot;
    logic [7:0]        ld_byte, rx_byte;
    logic [CS_W-1:0]   csel_q;

    qspi_regfile #(.SLOTS(SLOTS), .CS_W(CS_W), .MIN_DIV(MIN_DIV)) u_regs (
        .clk(clk), .rst(rst),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .done_pulse(done_pulse), .start(start),
        .div_q(div_q), .fmt_q(fmt_q), .first_q(first_q), .last_q(last_q),
        .lock_q(lock_q), .csel_q(csel_q), .irq(irq),
        .ld_slot(ld_slot), .ld_byte(ld_byte),
        .cur_slot(cur_slot), .cur_cont(cur_cont),
        .rx_we(rx_we), .rx_slot(cur_slot), .rx_byte(rx_byte)
    );

    qspi_shifter #(.SLOTS(SLOTS), .MIN_DIV(MIN_DIV)) u_shift (
        .clk(clk), .rst(rst), .start(start),
        .first_q(first_q), .last_q(last_q), .div_q(div_q), .fmt_q(fmt_q),
        .lock_q(lock_q), .ld_slot(ld_slot), .ld_byte(ld_byte),
        .cur_slot(cur_slot), .cur_cont(cur_cont), .miso(miso),
        .sck(sck), .mosi(mosi), .cs_on(cs_on), .busy(busy),
        .rx_we(rx_we), .rx_byte(rx_byte), .done_pulse(done_pulse)
    );

    assign ss_n = cs_on ? ~csel_q : '1;

    // R11
    select_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_on |-> (ss_n == '1));

endmodule

// File: tb/tb_qspi_master.sv
module tb_qspi_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, sck, mosi;
    logic        miso = 1'b0;
    logic [7:0]  ss_n;

    int checks = 0, failures = 0;
    logic [7:0] tx_m [16];
    logic [7:0] cmd_m [16];
    logic [7:0] reply [16];

    always #2.5 clk = ~clk;

    qspi_master dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        @(posedge clk);
        #1;
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic load_slot(input int s, input logic [7:0] tx, input logic [7:0] cmd,
                             input logic [7:0] rep);
        tx_m[s] = tx; cmd_m[s] = cmd; reply[s] = rep;
        bus_write(7'(32 + 2 * s), {24'd0, tx});
        bus_write(7'(96 + s), {24'd0, cmd});
    endtask

    // Behavioural model: predicts sck, mosi and ss_n on every clock of a queue.
    task automatic run_queue(input int first, input int last, input int d,
                             input logic cpol, input logic cpha, input logic [7:0] csel);
        int s = first;
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 7'd4; bus_wdata = 32'h60;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
        forever begin
            for (int t = 0; t < 16 * d; t++) begin
                if (t != 0) begin @(posedge clk); #1; end
                chk("R3/R11 select", {24'd0, ss_n}, {24'd0, ~csel});
                chk("R5 sck", {31'd0, sck}, {31'd0, cpol ^ (((t / d) % 2 == 1) ^ cpha)});
                chk("R3 mosi", {31'd0, mosi}, {31'd0, tx_m[s][7 - (t / d) / 2]});
                miso = reply[s][7 - (t / d) / 2];
            end
            if (s == last) break;
            if (!cmd_m[s][7]) begin
                for (int g = 0; g < d; g++) begin
                    @(posedge clk); #1;
                    chk("R6 gap select", {24'd0, ss_n}, 32'hFF);
                    chk("R6 gap sck", {31'd0, sck}, {31'd0, cpol});
                end
            end
            s = (s + 1) % 16;
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        miso = 1'b0;
        chk("R7 irq at finish", {31'd0, irq}, 32'd1);
        chk("R8 select after queue", {24'd0, ss_n},
            cmd_m[last][7] ? {24'd0, ~csel} : 32'hFF);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 ss_n", {24'd0, ss_n}, 32'hFF);
        chk("R1 sck", {31'd0, sck}, 32'd1);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        bus_read(7'd5, rd); chk("R1 status", rd, 32'd0);
        bus_read(7'd0, rd); chk("R1 divisor", rd, 32'd8);

        // R2: start without lock does nothing
        bus_write(7'd4, 32'h60);
        repeat (20) begin
            @(posedge clk); #1;
            chk("R2 no lock select", {24'd0, ss_n}, 32'hFF);
            chk("R2 no lock sck", {31'd0, sck}, 32'd1);
        end
        bus_read(7'd4, rd); chk("R2 not running", rd & 32'h40, 32'd0);
        bus_read(7'd5, rd); chk("R2 no completion", rd, 32'd0);

        // Queue A: mode 3, divisor 3 clamps to 8, slots 0..3
        bus_write(7'd6, 32'd1);
        bus_write(7'd7, 32'h04);
        bus_write(7'd0, 32'd3);
        bus_write(7'd1, 32'h0B);
        load_slot(0, 8'hA5, 8'h8E, 8'h3C);
        load_slot(1, 8'h01, 8'h8E, 8'hF0);
        load_slot(2, 8'h80, 8'h8E, 8'h81);
        load_slot(3, 8'h5A, 8'h0E, 8'h7E);
        bus_write(7'd2, 32'd0);
        bus_write(7'd3, 32'd3);
        run_queue(0, 3, 8, 1'b1, 1'b1, 8'h04);
        for (int s = 0; s < 4; s++) begin
            bus_read(7'(64 + 2 * s + 1), rd);
            chk("R4 rx word", rd, {24'd0, reply[s]});
        end
        bus_read(7'd5, rd); chk("R7 status set", rd, 32'd1);
        bus_read(7'd4, rd); chk("R7 run bit cleared", rd & 32'h40, 32'd0);

        // R9: clear completion
        bus_write(7'd5, 32'd0);
        #1;
        chk("R9 irq dropped", {31'd0, irq}, 32'd0);
        bus_read(7'd5, rd); chk("R9 status cleared", rd, 32'd0);

        // Queue B: mode 0, divisor 10, wraps 14,15,0, gap after 14, hold at end
        bus_write(7'd0, 32'd10);
        bus_write(7'd1, 32'h00);
        bus_write(7'd7, 32'h10);
        load_slot(14, 8'hC3, 8'h0E, 8'h55);
        load_slot(15, 8'h6D, 8'h8E, 8'hAA);
        load_slot(0, 8'h99, 8'h8E, 8'h0F);
        bus_write(7'd2, 32'd14);
        bus_write(7'd3, 32'd0);
        run_queue(14, 0, 10, 1'b0, 1'b0, 8'h10);
        bus_read(7'(64 + 29), rd); chk("R4 rx slot 14", rd, 32'h55);
        bus_read(7'(64 + 31), rd); chk("R4 rx slot 15", rd, 32'hAA);
        bus_read(7'(64 + 1), rd);  chk("R4 rx slot 0", rd, 32'h0F);
        repeat (5) @(posedge clk);
        #1;
        chk("R8 select held", {24'd0, ss_n}, 32'hEF);
        bus_write(7'd6, 32'd0);
        repeat (2) @(posedge clk);
        #1;
        chk("R8 select released by lock", {24'd0, ss_n}, 32'hFF);

        // R10: writes during a running queue are ignored
        bus_write(7'd6, 32'd1);
        bus_write(7'd0, 32'd8);
        load_slot(5, 8'h3B, 8'h0E, 8'hC6);
        bus_write(7'd2, 32'd5);
        bus_write(7'd3, 32'd5);
        fork
            run_queue(5, 5, 8, 1'b0, 1'b0, 8'h10);
            begin
                repeat (30) @(negedge clk);
                bus_write(7'(32 + 10), 32'hEE);
            end
        join
        bus_read(7'(32 + 10), rd); chk("R10 tx unchanged", rd, 32'h3B);
        bus_read(7'(64 + 11), rd); chk("R4 rx slot 5", rd, 32'hC6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule